// File: doc/BRIEF.md
# Non-Overlapping 101 Pattern Counter

This block is purely combinational. It takes a 32-bit word and reports how many times the bit pattern 101 appears in it, with the rule that two counted occurrences never share a bit. The word is read from its most significant bit downward. Each time three consecutive bits read 1, 0, 1, that occurrence is counted and all three bits are consumed.

The logic works in two stages.

- **Marker stage.** A per-position marker vector flags the bit that sits in the middle of each counted occurrence. Each marker is decided from its own three-bit window and from the marker decisions of the two positions above it. The topmost and bottommost positions can never be a middle bit.
- **Counting stage.** The markers are counted in groups of four bits. The group counts are then summed pairwise in a tree of adders.

Top module: `ones101_counter`

## Requirements
- R1: `count` equals the result of a greedy scan. Start at bit i = 31. If bits [i], [i-1] and [i-2] are 1, 0, 1, add one and continue at i-3. Otherwise continue at i-1. Stop when i < 2.
- R2: Occurrences share no bits. The word 0x15 (binary 10101) gives 1. The word 0x2D (binary 101101) gives 2.
- R3: `count` never exceeds 10, the largest count possible in 32 bits. The word 0xB6DB6DB6 (101101 repeated from the top) gives exactly 10.
- R4: Marked middle positions are always at least 3 bits apart.
- R5: Occurrences touching either end of the word are counted. 0xA0000000 (bits 31..29 = 101) gives 1. 0x00000005 (bits 2..0 = 101) gives 1. 0x00000002 gives 0.
- R6: A word containing no 101 anywhere gives 0, including all zeros and all ones. Any word containing at least one 101 gives a non-zero count.
- R7: A long alternating run is resolved along its whole length, not from a fixed window. Both 0xAAAAAAAA and 0x55555555 give 8.
- R8: `count` is a combinational function of `din` and is valid in the same cycle that `din` is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Word to scan |
| count | output | 4 | Number of non-overlapping 101 occurrences |

## Verification
Every result is due in the cycle its word is applied, with zero register stages between `din` and `count`. The bench therefore changes `din` at a falling clock edge and reads `count` 2 ns later, inside that same cycle. This keeps each sample clear of the rising edge, so no check depends on the order of processes at an edge. Expected values for the directed words are fixed numbers taken from the requirements. Expected values for the 100000 random and sparse words come from a greedy MSB-first scan written separately in the bench.

// File: rtl/ones101_counter.sv
module ones101_counter #(
  parameter int W  = 32,
  parameter int CW = $clog2(W / 3 + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] count
);
  localparam int NG = W / 4;
  localparam int LV = $clog2(NG);
  localparam int NP = 1 << LV;
  localparam int SW = $clog2(W + 1);

  logic [W-1:0]  hit;
  logic [W-1:0]  mark;
  logic [2:0]    grp [NG];
  logic [SW-1:0] total;

  // a 101 centred on bit n; a mark survives unless a mark above already took bit n+1
  for (genvar n = 0; n < W; n++) begin : g_pos
    if (n == 0 || n == W - 1) begin : g_edge
      assign hit[n]  = 1'b0;
      assign mark[n] = 1'b0;
    end else begin : g_mid
      assign hit[n] = din[n+1] & ~din[n] & din[n-1];
      if (n == W - 2) begin : g_top
        assign mark[n] = hit[n];
      end else if (n == W - 3) begin : g_top1
        assign mark[n] = hit[n] & ~mark[n+1];
      end else begin : g_gen
        assign mark[n] = hit[n] & ~mark[n+1] & ~mark[n+2];
      end
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp[g] = {2'b00, mark[4*g]}   + {2'b00, mark[4*g+1]}
                  + {2'b00, mark[4*g+2]} + {2'b00, mark[4*g+3]};
  end

  for (genvar l = 0; l <= LV; l++) begin : lvl
    logic [SW-1:0] s [NP >> l];
    for (genvar i = 0; i < (NP >> l); i++) begin : nd
      if (l == 0) begin : g_leaf
        if (i < NG) begin : g_used
          assign s[i] = SW'(grp[i]);
        end else begin : g_pad
          assign s[i] = '0;
        end
      end else begin : g_add
        assign s[i] = lvl[l-1].s[2*i] + lvl[l-1].s[2*i+1];
      end
    end
  end

  assign total = lvl[LV].s[0];
  assign count = total[CW-1:0];
endmodule

module ones101_counter_chk #(
  parameter int W  = 32,
  parameter int SW = 6,
  parameter int CW = 4
) (
  input logic [W-1:0]  din,
  input logic [W-1:0]  hit,
  input logic [W-1:0]  mark,
  input logic [SW-1:0] total,
  input logic [CW-1:0] count
);
  always_comb begin
    if (!$isunknown(din)) begin
      p_no_overflow_r3: assert (total <= SW'(W / 3))
        else $error("R3 total %0d above limit", total);
      p_spacing_r4: assert (((mark & (mark >> 1)) == '0) && ((mark & (mark >> 2)) == '0))
        else $error("R4 marks too close %h", mark);
      p_greedy_r1: assert ((hit & ~mark & ~(mark >> 1) & ~(mark >> 2)) == '0)
        else $error("R1 uncovered match %h", hit);
      p_zero_iff_none_r6: assert ((count == '0) == (hit == '0))
        else $error("R6 count %0d with matches %h", count, hit);
    end
  end
endmodule

bind ones101_counter ones101_counter_chk #(.W(W), .SW(SW), .CW(CW)) u_chk (
  .din(din), .hit(hit), .mark(mark), .total(total), .count(count)
);

// File: tb/sim_ones101_counter.sv
module sim_ones101_counter;
  logic        clk = 1'b0;
  logic [31:0] din = '0;
  logic [3:0]  count;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ones101_counter u0 (.din(din), .count(count));

  function automatic int ref_cnt(logic [31:0] w);
    int c = 0;
    int i = 31;
    while (i >= 2) begin
      if (w[i] && !w[i-1] && w[i-2]) begin
        c++;
        i -= 3;
      end else begin
        i--;
      end
    end
    return c;
  endfunction

  task automatic check(input logic [31:0] w, input int exp, input string req);
    @(negedge clk);
    din = w;
    #2;
    tests++;
    if (int'(count) != exp) begin
      fails++;
      $display("FAIL %s word=%h got=%0d exp=%0d", req, w, count, exp);
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    check(32'h0000_0000, 0, "R6 reset/all zeros");
    check(32'hFFFF_FFFF, 0, "R6 all ones");
    check(32'h0000_0015, 1, "R2 10101");
    check(32'h0000_002D, 2, "R2 101101");
    check(32'hB6DB_6DB6, 10, "R3 maximum");
    check(32'hA000_0000, 1, "R5 top edge");
    check(32'h0000_0005, 1, "R5 bottom edge");
    check(32'h0000_0002, 0, "R5 partial bottom");
    check(32'hA000_0005, 2, "R5 both edges");
    check(32'hAAAA_AAAA, 8, "R7 alternating A");
    check(32'h5555_5555, 8, "R7 alternating 5");
    check(32'h0000_0014, 1, "R1 single inner");
    check(32'h0000_00AD, 2, "R1 greedy order");
    for (int k = 0; k < 32; k++) begin
      check(32'h5 << k, (k < 30) ? 1 : ((k == 30) ? 0 : 0), "R5 sliding 101");
    end
    for (int k = 0; k < 100000; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (k % 3 == 1) w = w & $urandom;
      if (k % 3 == 2) w = w ^ 32'hAAAA_AAAA ^ ($urandom & $urandom & $urandom);
      check(w, ref_cnt(w), "R1 R8 random");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule